// File: doc/BRIEF.md
# Debounced Lift Floor Tracker

This block follows a lift car as it moves past a column of beam-break sensors, one sensor per floor. Each raw sensor line is active high: it reads 1 while the car cuts that beam. The lines are filtered by a slow sampler that is driven from one tap of a free-running counter. From the filtered vector and the motor status, the tracker keeps a registered floor number and a flag that says whether the car is level with a sensor.

Between two sensors the car sits in a blind spot and every sensor reads zero. In that case the tracker keeps the last floor it knew. Near a floor, two adjacent sensors can both be cut. The floor decision therefore looks at individual bits and never matches the whole vector against a one-hot pattern. When two bits are set, the motor direction decides between them while the car moves. When the motor is idle, the floor already held is kept if its bit is still set.

Top module: `floor_tracker`

## Requirements
- R1: While rst_n is low at a clock edge, floor_idx becomes 0 and at_floor becomes 0.
- R2: A sensor sample is taken only in the cycle after a rising edge of smp_tap. Holding smp_tap high takes no further samples, and changes to sens_raw during that time have no effect.
- R3: A debounced sensor bit becomes 1 only after three consecutive samples of 1 on its raw line.
- R4: A debounced sensor bit becomes 0 only after three consecutive samples of 0. Any mixed run of samples keeps its previous value.
- R5: When the debounced vector is all zeros (blind spot), floor_idx keeps its previous value and is never forced to 0.
- R6: Floor number n corresponds to bit n of sens_raw (bit 0 is the ground floor). floor_idx is always below the sensor count.
- R7: While mot_run is 1 and more than one debounced bit is set, floor_idx takes the lowest set bit when mot_dir is 0 (up) and the highest set bit when mot_dir is 1 (down).
- R8: While mot_run is 0, floor_idx is kept if its own debounced bit is set. Otherwise it takes the lowest set bit.
- R9: floor_idx is re-evaluated only in the cycle after the debounced vector changes to a nonzero value. at_floor is 1 exactly when the debounced vector was nonzero in the previous cycle. A change of mot_dir or mot_run alone does not move floor_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_tap | input | 1 | Slow counter bit; its rising edge triggers one sample |
| sens_raw | input | 5 | Raw beam-break sensors, bit n = floor n, 1 = beam cut |
| mot_run | input | 1 | 1 while the motor is driving the car |
| mot_dir | input | 1 | Motor direction, 0 = up, 1 = down |
| floor_idx | output | 3 | Current floor number |
| at_floor | output | 1 | 1 while some debounced sensor is active |

## Verification
The bench goes after blind spots, where a tracker that decodes the whole vector would fall back to floor 0. It checks adjacent sensor pairs, where a one-hot match finds no floor or a direction-blind choice reports the wrong neighbour in one travel direction. It checks short glitches of one or two samples, which a weak filter would let through as a floor change. It also checks a long high level on the sampling tap, which a level-triggered sampler would turn into many samples that quietly overwrite the filter. An idle car with two beams cut is checked as well, because jumping to another floor there would show a wrong number while the car stands still.

// File: rtl/ft_pkg.sv
// Shared constants and types for the floor tracker.
// Assumes one sensor per floor, with sensor n mounted at floor n.
package ft_pkg;
    parameter int unsigned FT_NUM_SENS = 5;
    parameter int unsigned FT_DB_LEN   = 3;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } mot_dir_e;
endpackage

// File: rtl/ft_tap_edge.sv
// Turns a slow counter bit into a one-cycle sample strobe on its rising edge.
// Assumes the tap is synchronous to clk (it comes from a counter on clk).
module ft_tap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_i,
    output logic strobe_o
);
    logic tap_q;

    // Remember the tap level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= 1'b0;
        else        tap_q <= tap_i;
    end

    assign strobe_o = tap_i & ~tap_q;

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
endmodule

// File: rtl/ft_debounce.sv
// Filters one sensor line with a short shift register clocked by a strobe.
// The output changes only when every stage agrees; mixed stages keep the output.
module ft_debounce #(
    parameter int unsigned DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    input  logic raw_i,
    output logic clean_o
);
    logic [DEPTH-1:0] stages_q;
    logic             clean_q;

    // Shift in one raw sample per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     stages_q <= '0;
        else if (smp_i) stages_q <= {stages_q[DEPTH-2:0], raw_i};
    end

    // Update the filtered level only on a unanimous history.
    always_ff @(posedge clk) begin
        if (!rst_n)                clean_q <= 1'b0;
        else if (&stages_q)        clean_q <= 1'b1;
        else if (stages_q == '0)   clean_q <= 1'b0;
    end

    assign clean_o = clean_q;

    // R2
    no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_i |=> $stable(stages_q));
    // R3
    rise_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clean_q) |-> ($past(stages_q) == {DEPTH{1'b1}}));
    // R4
    fall_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clean_q) |-> ($past(stages_q) == {DEPTH{1'b0}}));
endmodule

// File: rtl/ft_floor_resolve.sv
// Derives the floor number from the filtered sensor vector and motor status.
// Tests single bits, so zero vectors and adjacent pairs are both handled.
// Assumes bit n of the vector is the sensor at floor n.
module ft_floor_resolve #(
    parameter int unsigned NSENS   = 5,
    parameter int unsigned FLOOR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSENS-1:0]   clean_i,
    input  logic               run_i,
    input  ft_pkg::mot_dir_e   dir_i,
    output logic [FLOOR_W-1:0] floor_o,
    output logic               at_floor_o
);
    logic [NSENS-1:0]   prev_q;
    logic [FLOOR_W-1:0] floor_q;
    logic               at_q;
    logic [FLOOR_W-1:0] lo_idx, hi_idx, pick;
    logic               cur_set;

    // Find the lowest and highest active sensor positions.
    always_comb begin
        lo_idx = '0;
        hi_idx = '0;
        for (int i = NSENS - 1; i >= 0; i--)
            if (clean_i[i]) lo_idx = FLOOR_W'(i);
        for (int i = 0; i < NSENS; i++)
            if (clean_i[i]) hi_idx = FLOOR_W'(i);
    end

    // Check whether the held floor's own sensor is still active.
    always_comb begin
        cur_set = 1'b0;
        for (int i = 0; i < NSENS; i++)
            if (floor_q == FLOOR_W'(i) && clean_i[i]) cur_set = 1'b1;
    end

    // Choose the floor from direction when moving, or from the held floor when idle.
    always_comb begin
        if (run_i)        pick = (dir_i == ft_pkg::DIR_DOWN) ? hi_idx : lo_idx;
        else if (cur_set) pick = floor_q;
        else              pick = lo_idx;
    end

    // Hold state; re-evaluate only when the vector changes to a nonzero value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            floor_q <= '0;
            at_q    <= 1'b0;
        end else begin
            prev_q <= clean_i;
            at_q   <= |clean_i;
            if ((clean_i != prev_q) && (clean_i != '0))
                floor_q <= pick;
        end
    end

    assign floor_o    = floor_q;
    assign at_floor_o = at_q;

    // R5
    blind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_i == '0) |=> $stable(floor_q));
    // R9
    blind_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_i == '0) |=> !at_q);
    // R6
    floor_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        floor_q < FLOOR_W'(NSENS));
    // R9
    steady_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_i == prev_q) |=> $stable(floor_q));
    // R7
    picked_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clean_i != prev_q) && (clean_i != '0)) |=> (($past(clean_i) >> floor_q) & 1) != 0);
endmodule

// File: rtl/floor_tracker.sv
// Top of the floor tracker: tap strobe, per-sensor filters, floor resolver.
// Assumes smp_tap is a bit of a free-running counter on clk.
module floor_tracker #(
    parameter int unsigned NUM_SENS = ft_pkg::FT_NUM_SENS,
    parameter int unsigned DB_LEN   = ft_pkg::FT_DB_LEN,
    localparam int unsigned FLOOR_W = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_tap,
    input  logic [NUM_SENS-1:0] sens_raw,
    input  logic                mot_run,
    input  logic                mot_dir,
    output logic [FLOOR_W-1:0]  floor_idx,
    output logic                at_floor
);
    logic                smp_stb;
    logic [NUM_SENS-1:0] sens_clean;

    ft_tap_edge u_tap (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_i    (smp_tap),
        .strobe_o (smp_stb)
    );

    for (genvar g = 0; g < NUM_SENS; g++) begin : g_filt
        ft_debounce #(.DEPTH(DB_LEN)) u_db (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_i   (smp_stb),
            .raw_i   (sens_raw[g]),
            .clean_o (sens_clean[g])
        );
    end

    ft_floor_resolve #(.NSENS(NUM_SENS), .FLOOR_W(FLOOR_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .clean_i    (sens_clean),
        .run_i      (mot_run),
        .dir_i      (ft_pkg::mot_dir_e'(mot_dir)),
        .floor_o    (floor_idx),
        .at_floor_o (at_floor)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (floor_idx == '0 && !at_floor));
endmodule

// File: tb/floor_tracker_tb.sv
module floor_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_tap = 1'b0;
    logic [NS-1:0] sens_raw = '0;
    logic          mot_run = 1'b0;
    logic          mot_dir = 1'b0;
    logic [2:0]    floor_idx;
    logic          at_floor;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 0;

    // bench model
    logic [2:0]    hist_m [NS];
    logic [NS-1:0] deb_m = '0;
    logic [2:0]    fl_m = '0;
    logic          af_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    floor_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .smp_tap(smp_tap), .sens_raw(sens_raw),
        .mot_run(mot_run), .mot_dir(mot_dir),
        .floor_idx(floor_idx), .at_floor(at_floor)
    );

    function automatic logic [2:0] low_bit(logic [NS-1:0] v);
        for (int i = 0; i < NS; i++) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    function automatic logic [2:0] high_bit(logic [NS-1:0] v);
        for (int i = NS - 1; i >= 0; i--) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic check(string req, logic [2:0] fl_exp, logic af_exp);
        n_checks++;
        if (floor_idx !== fl_exp || at_floor !== af_exp) begin
            n_errors++;
            $display("FAIL %s: floor=%0d at_floor=%0b expected floor=%0d at_floor=%0b",
                     req, floor_idx, at_floor, fl_exp, af_exp);
        end
    endtask

    // advance the model by one sample of value v
    task automatic model_sample(logic [NS-1:0] v);
        logic [NS-1:0] old = deb_m;
        for (int i = 0; i < NS; i++) begin
            hist_m[i] = {hist_m[i][1:0], v[i]};
            if (hist_m[i] == 3'b111) deb_m[i] = 1'b1;
            else if (hist_m[i] == 3'b000) deb_m[i] = 1'b0;
        end
        if (deb_m != old && deb_m != '0) begin
            if (mot_run) fl_m = mot_dir ? high_bit(deb_m) : low_bit(deb_m);
            else if (!deb_m[fl_m]) fl_m = low_bit(deb_m);
        end
        af_m = |deb_m;
    endtask

    // one rising edge on the tap with raw value v, then wait for settling
    task automatic sample(logic [NS-1:0] v);
        @(negedge clk);
        sens_raw = v;
        smp_tap = 1'b1;
        @(negedge clk);
        smp_tap = 1'b0;
        repeat (3) @(negedge clk);
        model_sample(v);
    endtask

    task automatic sample_n(logic [NS-1:0] v, int n);
        for (int k = 0; k < n; k++) sample(v);
    endtask

    function automatic logic [NS-1:0] rand_pattern();
        int kind = $urandom % 4;
        int pos = $urandom % NS;
        case (kind)
            0: return '0;
            1: return NS'(1) << pos;
            2: return (pos < NS - 1) ? (NS'(3) << pos) : (NS'(1) << pos);
            default: return NS'($urandom);
        endcase
    endfunction

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NS; i++) hist_m[i] = 3'b000;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 3'd0, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", 3'd0, 1'b0);

        // R3: two samples are not enough, the third sets the bit
        mot_run = 1'b1; mot_dir = 1'b0;
        sample_n(5'b00100, 2);
        check("R3", 3'd0, 1'b0);
        sample(5'b00100);
        check("R3", 3'd2, 1'b1);
        check("R6", fl_m, af_m);

        // R4: glitch of two zeros keeps the bit; R5: three zeros is a blind spot
        sample_n(5'b00000, 2);
        check("R4", 3'd2, 1'b1);
        sample(5'b00100);
        sample_n(5'b00000, 2);
        check("R4", 3'd2, 1'b1);
        sample(5'b00000);
        check("R5", 3'd2, 1'b0);

        // R7: adjacent pair while moving up picks the lower floor
        sample_n(5'b00110, 3);
        check("R7", 3'd1, 1'b1);
        sample_n(5'b00000, 3);
        check("R5", 3'd1, 1'b0);
        // R7: moving down picks the upper floor
        mot_dir = 1'b1;
        sample_n(5'b00110, 3);
        check("R7", 3'd2, 1'b1);
        // R9: direction change alone does not move the floor
        mot_dir = 1'b0;
        repeat (4) @(negedge clk);
        check("R9", 3'd2, 1'b1);

        // R8: idle with the held floor still active keeps it
        sample_n(5'b00000, 3);
        mot_run = 1'b0;
        sample_n(5'b00110, 3);
        check("R8", 3'd2, 1'b1);
        sample_n(5'b00000, 3);
        sample_n(5'b11000, 3);
        check("R8", 3'd3, 1'b1);

        // R2: tap held high takes one sample only
        @(negedge clk);
        sens_raw = 5'b11000;
        smp_tap = 1'b1;
        @(negedge clk);
        sens_raw = 5'b00010;
        repeat (8) @(negedge clk);
        smp_tap = 1'b0;
        repeat (3) @(negedge clk);
        model_sample(5'b11000);
        check("R2", 3'd3, 1'b1);
        check("R2", fl_m, af_m);

        // constrained random bursts checked against the model
        for (int it = 0; it < 250; it++) begin
            logic [NS-1:0] pat = rand_pattern();
            int reps = 1 + ($urandom % 4);
            mot_run = 1'($urandom);
            mot_dir = 1'($urandom);
            for (int r = 0; r < reps; r++) begin
                sample(pat);
                if (mot_run) check("R7 random", fl_m, af_m);
                else         check("R8 random", fl_m, af_m);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule